// File: doc/BRIEF.md
# Traffic-Class Dimension-Order Route Unit

This unit computes the output channel for a head flit in a mesh router of a cache-bank network where most horizontal links have been removed. It compares the node's own coordinates with the destination coordinates. It also takes one class bit, which tells traffic heading from a core or memory controller toward a bank apart from traffic heading from a bank back to a core or memory. The unit then names one of five output ports: local eject, X+, X-, Y+ or Y-.

The dimension order depends on the class. Core/memory-to-bank traffic settles its whole X offset before it moves in Y. Bank-to-core/memory traffic settles its whole Y offset before it moves in X. This keeps horizontal hops confined to the rows that keep their links.

To support a near single-cycle router, the unit also works out the port the packet will need at the neighbour it is about to enter, which is look-ahead routing. Both results are registered and appear one cycle after a valid head flit. The result depends on no virtual-channel index, so it holds for all four virtual channels of a port.

Top module: `class_order_route`

## Requirements
- R1: After reset, valid_o, port_o and la_port_o are all zero.
- R2: port_o and la_port_o are one-hot with bit 0 = local, bit 1 = X+, bit 2 = X-, bit 3 = Y+, bit 4 = Y-. Offsets are destination minus current as signed values on unsigned 4-bit coordinates, with no wraparound. When both offsets are zero the result is local (bit 0).
- R3: With class bit from_bank_i = 0, a nonzero X offset selects X+ (positive offset) or X- (negative offset), whatever the Y offset is.
- R4: With from_bank_i = 0 and a zero X offset, a nonzero Y offset selects Y+ (positive) or Y- (negative).
- R5: With from_bank_i = 1, a nonzero Y offset selects Y+ or Y-, whatever the X offset is. For example, a negative Y offset with a positive X offset gives Y-.
- R6: With from_bank_i = 1 and a zero Y offset, a nonzero X offset selects X+ or X-.
- R7: la_port_o is the port that the R2 to R6 rules give at the neighbour reached through port_o, for the same destination and class. When port_o is local, la_port_o is local.
- R8: valid_o rises in the cycle after valid_i is high. port_o and la_port_o are captured only on such a cycle. While valid_i is low they hold their last value and valid_o is low.
- R9: Following port_o hop by hop from any source to any destination on an 8x8 mesh reaches local after exactly |dX|+|dY| hops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Head flit present this cycle |
| from_bank_i | input | 1 | 1 = bank-to-core/memory traffic (Y first), 0 = core/memory-to-bank traffic (X first) |
| cur_x_i | input | 4 | Current node X coordinate |
| cur_y_i | input | 4 | Current node Y coordinate |
| dst_x_i | input | 4 | Destination X coordinate |
| dst_y_i | input | 4 | Destination Y coordinate |
| valid_o | output | 1 | Registered results are fresh |
| port_o | output | 5 | One-hot output port for this hop |
| la_port_o | output | 5 | One-hot look-ahead port for the next hop |

## Verification
The current-hop decision and the look-ahead decision are made in the same cycle from one input vector. They can disagree at a dimension turn, where this hop is the last horizontal or vertical move and the next hop must switch axes, and at the final hop, where the next port becomes local. An exhaustive sweep over every source and destination pair in both classes reaches every turn and every final hop. Each hop's port and look-ahead are judged against a bench model of the two orders. The walk also confirms that each path length equals the Manhattan distance. Random vectors over the full 4-bit coordinate range and idle cycles between valid flits cover the edges and the hold behaviour.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int unsigned PORT_N  = 5;
  localparam int unsigned IDX_LOC = 0;
  localparam int unsigned IDX_XP  = 1;
  localparam int unsigned IDX_XM  = 2;
  localparam int unsigned IDX_YP  = 3;
  localparam int unsigned IDX_YM  = 4;

  typedef logic [PORT_N-1:0] port_t;

  localparam port_t PORT_LOC = port_t'(1) << IDX_LOC;
  localparam port_t PORT_XP  = port_t'(1) << IDX_XP;
  localparam port_t PORT_XM  = port_t'(1) << IDX_XM;
  localparam port_t PORT_YP  = port_t'(1) << IDX_YP;
  localparam port_t PORT_YM  = port_t'(1) << IDX_YM;
endpackage

// File: rtl/route_decide.sv
module route_decide
  import route_pkg::*;
#(
  parameter int unsigned COORD_W = 4
) (
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  input  logic               y_first_i,
  output port_t              port_o
);
  localparam int unsigned OFF_W = COORD_W + 1;

  logic signed [OFF_W-1:0] off_x, off_y;
  logic x_move, y_move, go_vert;

  assign off_x  = $signed({1'b0, dst_x_i}) - $signed({1'b0, cur_x_i});
  assign off_y  = $signed({1'b0, dst_y_i}) - $signed({1'b0, cur_y_i});
  assign x_move = (off_x != '0);
  assign y_move = (off_y != '0);
  // vertical now if Y-first with Y left, or X-first with X done
  assign go_vert = y_first_i ? y_move : !x_move;

  always_comb begin
    if (!x_move && !y_move) port_o = PORT_LOC;
    else if (go_vert)       port_o = off_y[OFF_W-1] ? PORT_YM : PORT_YP;
    else                    port_o = off_x[OFF_W-1] ? PORT_XM : PORT_XP;
  end
endmodule

// File: rtl/route_step.sv
module route_step
  import route_pkg::*;
#(
  parameter int unsigned COORD_W = 4
) (
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  port_t              port_i,
  output logic [COORD_W-1:0] nxt_x_o,
  output logic [COORD_W-1:0] nxt_y_o
);
  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  always_comb begin
    nxt_x_o = cur_x_i;
    nxt_y_o = cur_y_i;
    unique case (1'b1)
      port_i[IDX_XP]: nxt_x_o = cur_x_i + ONE;
      port_i[IDX_XM]: nxt_x_o = cur_x_i - ONE;
      port_i[IDX_YP]: nxt_y_o = cur_y_i + ONE;
      port_i[IDX_YM]: nxt_y_o = cur_y_i - ONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/class_order_route.sv
module class_order_route
  import route_pkg::*;
#(
  parameter int unsigned COORD_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               from_bank_i,
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output logic               valid_o,
  output logic [PORT_N-1:0]  port_o,
  output logic [PORT_N-1:0]  la_port_o
);
  port_t              hop_port, la_port;
  logic [COORD_W-1:0] nxt_x, nxt_y;

  route_decide #(.COORD_W(COORD_W)) u_hop (
    .cur_x_i(cur_x_i), .cur_y_i(cur_y_i),
    .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .y_first_i(from_bank_i), .port_o(hop_port)
  );

  route_step #(.COORD_W(COORD_W)) u_step (
    .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .port_i(hop_port),
    .nxt_x_o(nxt_x), .nxt_y_o(nxt_y)
  );

  route_decide #(.COORD_W(COORD_W)) u_ahead (
    .cur_x_i(nxt_x), .cur_y_i(nxt_y),
    .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .y_first_i(from_bank_i), .port_o(la_port)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      port_o    <= '0;
      la_port_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        port_o    <= hop_port;
        la_port_o <= la_port;
      end
    end
  end

  // R2
  onehot_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(port_o) == 1 && $countones(la_port_o) == 1));

  // R2
  local_at_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cur_x_i == dst_x_i && cur_y_i == dst_y_i |=> port_o[IDX_LOC]);

  // R3
  core_x_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !from_bank_i && cur_x_i != dst_x_i |=> (port_o[IDX_XP] || port_o[IDX_XM]));

  // R5: bank traffic never uses a horizontal link off its destination row
  bank_no_horiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && from_bank_i && cur_y_i != dst_y_i |=> !(port_o[IDX_XP] || port_o[IDX_XM]));

  // R7
  la_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && port_o[IDX_LOC] |-> la_port_o[IDX_LOC]);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(port_o) && $stable(la_port_o)));
endmodule

// File: tb/class_order_route_bench.sv
module class_order_route_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0, from_bank = 1'b0;
  logic [3:0] cx = '0, cy = '0, dx = '0, dy = '0;
  logic       valid_o;
  logic [4:0] port_o, la_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  class_order_route u_class_order_route (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .from_bank_i(from_bank),
    .cur_x_i(cx), .cur_y_i(cy), .dst_x_i(dx), .dst_y_i(dy),
    .valid_o(valid_o), .port_o(port_o), .la_port_o(la_o)
  );

  function automatic logic [4:0] ref_port(int x, int y, int tx, int ty, bit fb);
    int ox = tx - x;
    int oy = ty - y;
    if (ox == 0 && oy == 0) return 5'b00001;
    if (fb ? (oy != 0) : (ox == 0)) return (oy > 0) ? 5'b01000 : 5'b10000;
    return (ox > 0) ? 5'b00010 : 5'b00100;
  endfunction

  function automatic int step_x(int x, logic [4:0] p);
    if (p == 5'b00010) return x + 1;
    if (p == 5'b00100) return x - 1;
    return x;
  endfunction

  function automatic int step_y(int y, logic [4:0] p);
    if (p == 5'b01000) return y + 1;
    if (p == 5'b10000) return y - 1;
    return y;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one hop: drive at negedge, result visible after the next posedge
  task automatic hop(int x, int y, int tx, int ty, bit fb);
    logic [4:0] ep, el;
    ep = ref_port(x, y, tx, ty, fb);
    el = ref_port(step_x(x, ep), step_y(y, ep), tx, ty, fb);
    valid_i = 1'b1; from_bank = fb;
    cx = 4'(x); cy = 4'(y); dx = 4'(tx); dy = 4'(ty);
    @(posedge clk); @(negedge clk);
    check("R8 valid", 32'(valid_o), 32'd1);
    if (tx == x && ty == y)       check("R2 port", 32'(port_o), 32'(ep));
    else if (fb && ty != y)       check("R5 port", 32'(port_o), 32'(ep));
    else if (fb)                  check("R6 port", 32'(port_o), 32'(ep));
    else if (tx != x)             check("R3 port", 32'(port_o), 32'(ep));
    else                          check("R4 port", 32'(port_o), 32'(ep));
    check("R7 look-ahead", 32'(la_o), 32'(el));
  endtask

  task automatic walk(int sx, int sy, int tx, int ty, bit fb);
    int x = sx, y = sy, n = 0;
    logic [4:0] p;
    while (n < 40) begin
      hop(x, y, tx, ty, fb);
      p = port_o;
      if (p == 5'b00001 || $countones(p) != 1) break;
      x = step_x(x, p); y = step_y(y, p); n++;
    end
    check("R9 path length", 32'(n), 32'(iabs(tx - sx) + iabs(ty - sy)));
  endtask

  initial begin
    logic [4:0] hp, hl;
    int unsigned seed;
    #1;
    @(negedge clk);
    check("R1 valid_o", 32'(valid_o), 32'd0);
    check("R1 port_o", 32'(port_o), 32'd0);
    check("R1 la_port_o", 32'(la_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    hop(3, 5, 6, 2, 1'b1);   // R5: Y- before X+
    hop(1, 1, 4, 6, 1'b0);   // R3: X+ first
    hop(4, 1, 4, 6, 1'b0);   // R4: then Y+
    hop(7, 3, 7, 4, 1'b0);   // R7 final hop turns to local
    hop(2, 2, 2, 2, 1'b1);   // R2 local
    hop(0, 0, 15, 15, 1'b0);
    hop(15, 15, 0, 0, 1'b1);

    // R8: idle cycles hold outputs
    hp = port_o; hl = la_o;
    valid_i = 1'b0; cx = 4'd9; cy = 4'd1; dx = 4'd0; dy = 4'd12; from_bank = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      check("R8 idle valid_o", 32'(valid_o), 32'd0);
      check("R8 idle port_o hold", 32'(port_o), 32'(hp));
      check("R8 idle la hold", 32'(la_o), 32'(hl));
    end

    // exhaustive 8x8 sweep, both classes
    for (int fb = 0; fb < 2; fb++)
      for (int s = 0; s < 64; s++)
        for (int d = 0; d < 64; d++)
          walk(s % 8, s / 8, d % 8, d / 8, fb[0]);

    // random single hops over the full coordinate range
    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < 3000; k++) begin
      hop(int'($urandom % 16), int'($urandom % 16),
          int'($urandom % 16), int'($urandom % 16), bit'($urandom % 2));
      if ($urandom % 8 == 0) begin
        hp = port_o; hl = la_o;
        valid_i = 1'b0; cx = ~cx;
        @(posedge clk); @(negedge clk);
        check("R8 gap hold port", 32'(port_o), 32'(hp));
        check("R8 gap hold la", 32'(la_o), 32'(hl));
        check("R8 gap valid_o", 32'(valid_o), 32'd0);
      end
    end

    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule